// File: doc/BRIEF.md
# BCD Alarm Comparator with Repeat Masks

This block holds a programmable alarm made of four BCD fields (seconds, minutes, hours, day-of-month) and compares it against a running BCD time of day. The comparison happens only on a once-per-second tick. When the alarm condition holds on a tick, the block emits a single-cycle interrupt pulse.

Software programs the four fields through a byte-wide write port and can read them back through a separate read address. Each field's bit 7 is a mask. The masks select how often the alarm repeats: monthly, daily, hourly, every minute or every second. Each write is range-checked as BCD for its field. A value that fails the check is dropped without any effect.

Top module: `bcd_alarm_match`

## Requirements
- R1: Four alarm bytes sit at offsets 0 (seconds), 1 (minutes), 2 (hours) and 3 (date). An accepted write stores the full byte, and `rd_data` returns the stored byte at `rd_addr` in the cycle after the write.
- R2: A seconds or minutes write is accepted only if bits 6:0, read as BCD, have both digits at most 9 and a value from 0 to 59.
- R3: An hours write is accepted only if bits 5:0, read as BCD, have both digits at most 9 and a value from 0 to 23.
- R4: A date write is accepted only if bits 5:0, read as BCD, have both digits at most 9 and a nonzero value.
- R5: A rejected write changes neither the stored byte nor the alarm behaviour.
- R6: With all four mask bits clear, a tick fires only when date, hours, minutes and seconds all match. Fields compare on bits 6:0 for seconds and minutes and on bits 5:0 for hours and date.
- R7: With only the date mask set, a tick fires when hours, minutes and seconds match.
- R8: With the date and hours masks set, and the minutes and seconds masks clear, a tick fires when minutes and seconds match.
- R9: With the date, hours and minutes masks set, and the seconds mask clear, a tick fires when seconds match.
- R10: Any other mask combination fires on every tick.
- R11: `irq_pulse` is high for exactly the one cycle after a firing tick. Without a tick it stays low, even when the fields match.
- R12: Reset clears all four alarm bytes and holds `irq_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for an alarm byte |
| wr_addr | input | 2 | Field offset being written |
| wr_data | input | 8 | Byte to write, with the mask in bit 7 |
| rd_addr | input | 2 | Field offset to read back |
| rd_data | output | 8 | Stored alarm byte at rd_addr |
| tick | input | 1 | One-cycle strobe once per second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| irq_pulse | output | 1 | One-cycle alarm interrupt |

## Verification
The bench writes values just past each range limit (seconds 60, hours 24, date 00) and values with a non-decimal digit (0x3A, 0x1A, 0x0A). A checker that only compared binary ranges would store those bytes, and a later readback or match would show it. It steps through every cumulative mask pattern, then a non-cumulative one. In each pattern it changes one field that should be ignored and one field that should matter. A design with a wrong mode decode would fire on the wrong field, or fail to fire. It also holds a matching time with no tick and checks that the pulse falls after one cycle. This catches a level-style interrupt or a missing tick gate.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DATE = 2'd3
    } field_e;

    typedef enum logic [2:0] {
        RPT_MONTH,
        RPT_DAY,
        RPT_HOUR,
        RPT_MIN,
        RPT_SEC
    } repeat_e;

    // significant bits compared and checked for each field
    function automatic logic [7:0] field_bits(input int unsigned idx);
        return (idx < 2) ? 8'h7F : 8'h3F;
    endfunction

    function automatic logic digits_ok(input logic [7:0] v);
        return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    endfunction

    function automatic logic [7:0] bcd_value(input logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

endpackage

// File: rtl/alarm_wr_check.sv
module alarm_wr_check
    import alarm_pkg::*;
#(
    parameter int DW = 8
) (
    input  field_e          fld,
    input  logic [DW-1:0]   data,
    output logic            ok
);
    logic [7:0] v;
    logic [7:0] val;

    always_comb begin
        v   = data[7:0] & field_bits(int'(fld));
        val = bcd_value(v);
        ok  = 1'b0;
        case (fld)
            FLD_SEC, FLD_MIN: ok = digits_ok(v) && (val <= 8'd59);
            FLD_HOUR:         ok = digits_ok(v) && (val <= 8'd23);
            FLD_DATE:         ok = digits_ok(v) && (val != 8'd0);
            default:          ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs #(
    parameter int NF = 4,
    parameter int DW = 8,
    localparam int AW = $clog2(NF)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic                   wr_ok,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data,
    output logic [NF-1:0][DW-1:0]  regs
);
    typedef struct packed {
        logic [NF-1:0][DW-1:0] field;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NF; i++) begin
            if (wr_en && wr_ok && (wr_addr == AW'(i)))
                st_d.field[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.field[rd_addr];
    assign regs    = st_q.field;

    // R5
    reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok) |=> $stable(st_q));
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_pkg::*;
#(
    parameter int NF = 4,
    parameter int DW = 8
) (
    input  logic [NF-1:0][DW-1:0] regs,
    input  logic [NF-1:0][DW-1:0] cur,
    output repeat_e               mode,
    output logic                  match
);
    logic [NF-1:0] eq;
    logic [NF-1:0] msk;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        assign eq[i]  = ((regs[i][7:0] ^ cur[i][7:0]) & field_bits(i)) == 8'h00;
        assign msk[i] = regs[i][DW-1];
    end

    always_comb begin
        case (msk)
            4'b0000: mode = RPT_MONTH;
            4'b1000: mode = RPT_DAY;
            4'b1100: mode = RPT_HOUR;
            4'b1110: mode = RPT_MIN;
            default: mode = RPT_SEC;
        endcase
        case (mode)
            RPT_MONTH: match = &eq;
            RPT_DAY:   match = &eq[2:0];
            RPT_HOUR:  match = &eq[1:0];
            RPT_MIN:   match = eq[0];
            default:   match = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
    import alarm_pkg::*;
#(
    parameter int NF = 4,
    parameter int DW = 8,
    localparam int AW = $clog2(NF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          tick,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [DW-1:0] cur_date,
    output logic          irq_pulse
);
    typedef struct packed {
        logic irq;
    } out_t;

    out_t                  o_d, o_q;
    logic                  wr_ok;
    logic [NF-1:0][DW-1:0] regs;
    logic [NF-1:0][DW-1:0] cur;
    repeat_e               mode;
    logic                  match;

    assign cur = {cur_date, cur_hour, cur_min, cur_sec};

    alarm_wr_check #(.DW(DW)) u_chk (
        .fld  (field_e'(wr_addr)),
        .data (wr_data),
        .ok   (wr_ok)
    );

    alarm_regs #(.NF(NF), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_ok   (wr_ok),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .regs    (regs)
    );

    alarm_cmp #(.NF(NF), .DW(DW)) u_cmp (
        .regs  (regs),
        .cur   (cur),
        .mode  (mode),
        .match (match)
    );

    always_comb begin
        o_d     = o_q;
        o_d.irq = tick && match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_pulse = o_q.irq;

    // R11
    no_tick_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !irq_pulse);
    // R11
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(tick));
    // R10
    every_sec_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == RPT_SEC) |=> irq_pulse);
    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !irq_pulse);
endmodule

// File: tb/bcd_alarm_match_bench.sv
module bcd_alarm_match_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = 8'h01;
    logic       irq_pulse;
    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    bcd_alarm_match u_bcd_alarm_match (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_date(cur_date), .irq_pulse(irq_pulse)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic set_time(input logic [7:0] d, input logic [7:0] h,
                            input logic [7:0] m, input logic [7:0] s);
        cur_date = d; cur_hour = h; cur_min = m; cur_sec = s;
    endtask

    // tick, then check the pulse and that it drops one cycle later
    task automatic tick_chk(input string req, input logic exp);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(req, {7'd0, irq_pulse}, {7'd0, exp});
        @(negedge clk);
        check("R11 single pulse", {7'd0, irq_pulse}, 8'h00);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) rd_chk("R12 reset value", 2'(i), 8'h00);
        check("R12 irq low", {7'd0, irq_pulse}, 8'h00);
    endtask

    task automatic t_store;
        wr(2'd0, 8'h30); wr(2'd1, 8'h45); wr(2'd2, 8'h12); wr(2'd3, 8'h15);
        rd_chk("R1 sec", 2'd0, 8'h30);
        rd_chk("R1 min", 2'd1, 8'h45);
        rd_chk("R1 hour", 2'd2, 8'h12);
        rd_chk("R1 date", 2'd3, 8'h15);
    endtask

    task automatic t_reject;
        wr(2'd0, 8'h60); rd_chk("R2 sec 60 rejected", 2'd0, 8'h30);
        wr(2'd0, 8'h3A); rd_chk("R2 sec bad digit", 2'd0, 8'h30);
        wr(2'd1, 8'h5F); rd_chk("R2 min bad digit", 2'd1, 8'h45);
        wr(2'd1, 8'h59); rd_chk("R2 min 59 accepted", 2'd1, 8'h59);
        wr(2'd1, 8'h45);
        wr(2'd2, 8'h24); rd_chk("R3 hour 24 rejected", 2'd2, 8'h12);
        wr(2'd2, 8'h1A); rd_chk("R3 hour bad digit", 2'd2, 8'h12);
        wr(2'd2, 8'h23); rd_chk("R3 hour 23 accepted", 2'd2, 8'h23);
        wr(2'd2, 8'h12);
        wr(2'd3, 8'h00); rd_chk("R4 date zero rejected", 2'd3, 8'h15);
        wr(2'd3, 8'h0A); rd_chk("R4 date bad digit", 2'd3, 8'h15);
        wr(2'd3, 8'h01); rd_chk("R4 date 01 accepted", 2'd3, 8'h01);
        wr(2'd3, 8'h15);
        // R5: matching still follows the earlier setting
        set_time(8'h15, 8'h12, 8'h45, 8'h30);
        tick_chk("R5 old setting still fires", 1'b1);
    endtask

    task automatic t_month;
        set_time(8'h15, 8'h12, 8'h45, 8'h30);
        tick_chk("R6 full match fires", 1'b1);
        set_time(8'h16, 8'h12, 8'h45, 8'h30);
        tick_chk("R6 date differs", 1'b0);
        // no tick: no pulse even with a match
        set_time(8'h15, 8'h12, 8'h45, 8'h30);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R11 no tick no pulse", {7'd0, irq_pulse}, 8'h00);
        end
    endtask

    task automatic t_day;
        wr(2'd3, 8'h95);
        set_time(8'h03, 8'h12, 8'h45, 8'h30);
        tick_chk("R7 daily ignores date", 1'b1);
        set_time(8'h03, 8'h12, 8'h45, 8'h31);
        tick_chk("R7 sec differs", 1'b0);
    endtask

    task automatic t_hour;
        wr(2'd2, 8'h92);
        set_time(8'h03, 8'h07, 8'h45, 8'h30);
        tick_chk("R8 hourly ignores hour", 1'b1);
        set_time(8'h03, 8'h07, 8'h44, 8'h30);
        tick_chk("R8 min differs", 1'b0);
    endtask

    task automatic t_minute;
        wr(2'd1, 8'hC5);
        set_time(8'h03, 8'h07, 8'h10, 8'h30);
        tick_chk("R9 minute ignores min", 1'b1);
        set_time(8'h03, 8'h07, 8'h10, 8'h29);
        tick_chk("R9 sec differs", 1'b0);
    endtask

    task automatic t_second;
        wr(2'd0, 8'hB0);
        set_time(8'h03, 8'h07, 8'h10, 8'h02);
        tick_chk("R10 all masked fires", 1'b1);
        // non-cumulative pattern: only the seconds mask set
        wr(2'd1, 8'h45); wr(2'd2, 8'h12); wr(2'd3, 8'h15);
        rd_chk("R1 masked sec stored", 2'd0, 8'hB0);
        set_time(8'h20, 8'h01, 8'h02, 8'h03);
        tick_chk("R10 odd mask fires", 1'b1);
        // back-to-back ticks give one pulse each
        @(negedge clk); tick = 1'b1;
        @(negedge clk);
        check("R10 first tick", {7'd0, irq_pulse}, 8'h01);
        @(negedge clk); tick = 1'b0;
        check("R10 second tick", {7'd0, irq_pulse}, 8'h01);
        @(negedge clk);
        check("R11 drops after ticks", {7'd0, irq_pulse}, 8'h00);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        t_reset();
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store();
        t_reject();
        t_month();
        t_day();
        t_hour();
        t_minute();
        t_second();
        t_reset_again();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule